// File: doc/BRIEF.md
# Grouped Timer Interrupt Request Router

This block collects event pulses from eight capture/compare channels and from one base timer and turns them into three interrupt request flags plus one DMA request line per source. Each channel pulse is latched into a sticky bit of a channel status register. Two independent enable masks select which latched channels feed combined channel interrupt A and combined channel interrupt B. A third flag, the base interrupt, is raised when the base timer reports an overflow or a reset.

A combined flag is raised only when the OR of its masked status bits goes from 0 to 1. Acknowledging a flag never touches the status bits, so software must clear those bits itself. A status bit left at 1 keeps the masked OR high and hides later channel events from that combined interrupt. A small register port gives read and write access to the status register, both masks and the flag bits. Each flag also has its own acknowledge input.

Top module: `tir_router`

## Requirements
- R1: A one-cycle pulse on `ch_req_i[i]` sets status bit i (register select 0) at the next clock edge. The bit stays at 1 until software writes 0 to it.
- R2: A pulse on `bt_ovf_i` or on `bt_rst_i` sets `irq_base_o` at the next clock edge.
- R3: `irq_grp0_o` is set at the clock edge after the OR of (status AND mask A, register select 1) rises from 0 to 1. After a channel pulse it is therefore high two edges later.
- R4: `irq_grp1_o` follows the same rule using mask B (register select 2). One channel enabled in both masks raises both flags in the same cycle.
- R5: Each of `ack_grp0_i`, `ack_grp1_i` and `ack_base_i` clears only its own flag at the next edge and leaves the status register unchanged.
- R6: While any status bit enabled in a mask stays at 1, a new enabled channel pulse raises no new request on that combined flag. Once the status is cleared, a new pulse raises it again.
- R7: Each channel pulse gives a one-cycle pulse on `dma_ch_o[i]`, and each base-timer pulse gives a one-cycle pulse on `dma_base_o`, in both cases one edge after the event.
- R8: Register select 0, 1 and 2 (status, mask A, mask B) read back the value written. Select 3 reads the flags at bit 0 (A), bit 1 (B) and bit 2 (base). Writing 0 to a flag bit clears that flag, and writing 1 has no effect.
- R9: A source event in the same cycle as a clear (software write or acknowledge) of the bit or flag it sets leaves that bit or flag at 1.
- R10: A synchronous active-high reset clears all registers, flags and DMA outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req_i | input | 8 | Channel event pulses |
| bt_ovf_i | input | 1 | Base timer overflow pulse |
| bt_rst_i | input | 1 | Base timer reset pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 status, 1 mask A, 2 mask B, 3 flags) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| ack_grp0_i | input | 1 | Acknowledge for combined interrupt A |
| ack_grp1_i | input | 1 | Acknowledge for combined interrupt B |
| ack_base_i | input | 1 | Acknowledge for base interrupt |
| irq_grp0_o | output | 1 | Combined interrupt A request flag |
| irq_grp1_o | output | 1 | Combined interrupt B request flag |
| irq_base_o | output | 1 | Base timer interrupt request flag |
| dma_ch_o | output | 8 | Per-channel DMA request pulses |
| dma_base_o | output | 1 | Base timer DMA request pulse |

## Verification
A wrong edge-detect register inside a combined flag shows up in one of two ways. It may raise a spurious request when a mask is rewritten while its masked OR is already high. It may also miss the blocking case, where a stale status bit should hide a second pulse. Both effects are visible on the flag pin two edges after the pulse. A corrupted status bit appears on a register read one edge after the pulse, and the same bit reaches the combined flag on the following edge. Set-versus-clear priority errors show up in the cycle right after the collision, which is why those cases are checked there.

// File: rtl/tir_pkg.sv
package tir_pkg;
    localparam int SEL_W    = 2;
    localparam int N_GROUPS = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASKA  = 2'd1,
        SEL_MASKB  = 2'd2,
        SEL_FLAGS  = 2'd3
    } reg_sel_e;

    localparam int FLG_A    = 0;
    localparam int FLG_B    = 1;
    localparam int FLG_BASE = 2;
    localparam int N_FLAGS  = 3;

    typedef struct packed {
        logic     we;
        reg_sel_e sel;
    } reg_wr_t;

    // set has priority over clear
    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction
endpackage

// File: rtl/tir_chan_regs.sv
module tir_chan_regs
    import tir_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_CH-1:0]                 ch_req,
    input  reg_wr_t                           wr,
    input  logic [NUM_CH-1:0]                 wdata,
    output logic [NUM_CH-1:0]                 status_o,
    output logic [N_GROUPS-1:0][NUM_CH-1:0]   mask_o
);
    logic [NUM_CH-1:0] status_q;
    logic [N_GROUPS-1:0][NUM_CH-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (wr.we && wr.sel == SEL_STATUS) begin
            status_q <= wdata | ch_req;
        end else begin
            status_q <= status_q | ch_req;
        end
    end

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_mask
        localparam reg_sel_e MY_SEL = (g == 0) ? SEL_MASKA : SEL_MASKB;
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[g] <= '0;
            end else if (wr.we && wr.sel == MY_SEL) begin
                mask_q[g] <= wdata;
            end
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R1
        status_set_chk: assert property (@(posedge clk) disable iff (rst)
            ch_req[i] |=> status_q[i]);
        // R1
        status_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (status_q[i] && !(wr.we && wr.sel == SEL_STATUS)) |=> status_q[i]);
    end
endmodule

// File: rtl/tir_group_flag.sv
module tir_group_flag
    import tir_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] status,
    input  logic [NUM_CH-1:0] mask,
    input  logic              ack,
    input  logic              sw_clr,
    output logic              flag_o
);
    logic any_now;
    logic any_prev_q;
    logic rise;
    logic flag_q;

    assign any_now = |(status & mask);
    assign rise    = any_now & ~any_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            any_prev_q <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            any_prev_q <= any_now;
            flag_q     <= flag_next(flag_q, rise, ack | sw_clr);
        end
    end

    assign flag_o = flag_q;

    // R3, R4
    grp_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> flag_q);
    // R5
    grp_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !rise) |=> !flag_q);
    // R6
    grp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (any_prev_q && !flag_q) |=> !flag_q);
endmodule

// File: rtl/tir_base_flag.sv
module tir_base_flag
    import tir_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ovf,
    input  logic tmr_rst,
    input  logic ack,
    input  logic sw_clr,
    output logic flag_o,
    output logic dma_o
);
    logic ev;
    logic flag_q;
    logic dma_q;

    assign ev = ovf | tmr_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            dma_q  <= 1'b0;
        end else begin
            flag_q <= flag_next(flag_q, ev, ack | sw_clr);
            dma_q  <= ev;
        end
    end

    assign flag_o = flag_q;
    assign dma_o  = dma_q;

    // R2
    base_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf || tmr_rst) |=> flag_q);
    // R7
    base_dma_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovf || tmr_rst) |=> !dma_o);
endmodule

// File: rtl/tir_dma_pulse.sv
module tir_dma_pulse #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_req,
    output logic [NUM_CH-1:0] dma_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= ch_req[i];
        end
        assign dma_o[i] = q;
        // R7
        dma_follow_chk: assert property (@(posedge clk) disable iff (rst)
            ch_req[i] |=> dma_o[i]);
    end
endmodule

// File: rtl/tir_router.sv
module tir_router
    import tir_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_req_i,
    input  logic              bt_ovf_i,
    input  logic              bt_rst_i,
    input  logic              reg_we_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [NUM_CH-1:0] reg_wdata_i,
    output logic [NUM_CH-1:0] reg_rdata_o,
    input  logic              ack_grp0_i,
    input  logic              ack_grp1_i,
    input  logic              ack_base_i,
    output logic              irq_grp0_o,
    output logic              irq_grp1_o,
    output logic              irq_base_o,
    output logic [NUM_CH-1:0] dma_ch_o,
    output logic              dma_base_o
);
    localparam int FLAG_PAD = NUM_CH - N_FLAGS;

    reg_wr_t wr;
    logic [NUM_CH-1:0] status;
    logic [N_GROUPS-1:0][NUM_CH-1:0] mask;
    logic [N_GROUPS-1:0] grp_flag;
    logic [N_GROUPS-1:0] grp_ack;
    logic [N_FLAGS-1:0]  sw_clr;
    logic [N_FLAGS-1:0]  flags;
    logic base_flag;

    assign wr.we  = reg_we_i;
    assign wr.sel = reg_sel_e'(reg_sel_i);

    for (genvar f = 0; f < N_FLAGS; f++) begin : g_clr
        assign sw_clr[f] = wr.we && (wr.sel == SEL_FLAGS) && !reg_wdata_i[f];
    end

    tir_chan_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst), .ch_req(ch_req_i), .wr(wr),
        .wdata(reg_wdata_i), .status_o(status), .mask_o(mask)
    );

    assign grp_ack = {ack_grp1_i, ack_grp0_i};

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        tir_group_flag #(.NUM_CH(NUM_CH)) u_flag (
            .clk(clk), .rst(rst), .status(status), .mask(mask[g]),
            .ack(grp_ack[g]), .sw_clr(sw_clr[g]), .flag_o(grp_flag[g])
        );
    end

    tir_base_flag u_base (
        .clk(clk), .rst(rst), .ovf(bt_ovf_i), .tmr_rst(bt_rst_i),
        .ack(ack_base_i), .sw_clr(sw_clr[FLG_BASE]),
        .flag_o(base_flag), .dma_o(dma_base_o)
    );

    tir_dma_pulse #(.NUM_CH(NUM_CH)) u_dma (
        .clk(clk), .rst(rst), .ch_req(ch_req_i), .dma_o(dma_ch_o)
    );

    assign flags[FLG_A]    = grp_flag[0];
    assign flags[FLG_B]    = grp_flag[1];
    assign flags[FLG_BASE] = base_flag;

    always_comb begin
        unique case (wr.sel)
            SEL_STATUS: reg_rdata_o = status;
            SEL_MASKA:  reg_rdata_o = mask[0];
            SEL_MASKB:  reg_rdata_o = mask[1];
            default:    reg_rdata_o = {{FLAG_PAD{1'b0}}, flags};
        endcase
    end

    assign irq_grp0_o = grp_flag[0];
    assign irq_grp1_o = grp_flag[1];
    assign irq_base_o = base_flag;

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags == '0 && status == '0 && dma_ch_o == '0 && !dma_base_o));
endmodule

// File: tb/tir_router_test.sv
`timescale 1ns/1ps
module tir_router_test;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] ch_req = '0;
    logic bt_ovf = 1'b0, bt_rst = 1'b0;
    logic we = 1'b0;
    logic [1:0] sel = '0;
    logic [NCH-1:0] wdata = '0;
    logic [NCH-1:0] rdata;
    logic ack0 = 1'b0, ack1 = 1'b0, ackb = 1'b0;
    logic irq0, irq1, irqb;
    logic [NCH-1:0] dma_ch;
    logic dma_b;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tir_router #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst), .ch_req_i(ch_req), .bt_ovf_i(bt_ovf), .bt_rst_i(bt_rst),
        .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ack_grp0_i(ack0), .ack_grp1_i(ack1), .ack_base_i(ackb),
        .irq_grp0_o(irq0), .irq_grp1_o(irq1), .irq_base_o(irqb),
        .dma_ch_o(dma_ch), .dma_base_o(dma_b)
    );

    typedef struct packed {
        logic [1:0]     s;
        logic [NCH-1:0] w;
        logic [NCH-1:0] e;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd0, 8'hA5, 8'hA5},
        '{2'd0, 8'h00, 8'h00},
        '{2'd1, 8'h3C, 8'h3C},
        '{2'd2, 8'hC3, 8'hC3},
        '{2'd3, 8'hFF, 8'h00}
    };

    task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [NCH-1:0] d);
        we = 1'b1; sel = s; wdata = d;
        cyc();
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [NCH-1:0] d);
        sel = s; #0.1; d = rdata;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [NCH-1:0] v;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        // R10 reset state
        for (int k = 0; k < 4; k++) begin
            rd(k[1:0], v);
            chk("R10 reg", v, '0);
        end
        chk("R10 irq", {5'd0, irqb, irq1, irq0}, '0);
        chk("R10 dma", dma_ch, '0);

        // R8 table walk
        for (int k = 0; k < 5; k++) begin
            wr(VECS[k].s, VECS[k].w);
            rd(VECS[k].s, v);
            chk("R8 readback", v, VECS[k].e);
        end

        // R1 R3 R4 R7: channel 0 enabled in both masks
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h03);
        ch_req = 8'h01;
        cyc();
        ch_req = '0;
        rd(2'd0, v);
        chk("R1 status set", v, 8'h01);
        chk("R7 dma pulse", dma_ch, 8'h01);
        chk("R3 not yet", {7'd0, irq0}, 8'h00);
        cyc();
        chk("R3 grp0 flag", {7'd0, irq0}, 8'h01);
        chk("R4 grp1 flag", {7'd0, irq1}, 8'h01);
        chk("R7 dma single", dma_ch, 8'h00);

        // R5 ack leaves status
        ack0 = 1'b1;
        cyc();
        ack0 = 1'b0;
        chk("R5 ack clears", {7'd0, irq0}, 8'h00);
        chk("R5 other flag kept", {7'd0, irq1}, 8'h01);
        rd(2'd0, v);
        chk("R5 status kept", v, 8'h01);

        // R6 blocking by stale status bit
        wr(2'd1, 8'h05);
        ch_req = 8'h04;
        cyc();
        ch_req = '0;
        cyc(); cyc();
        chk("R6 blocked", {7'd0, irq0}, 8'h00);
        rd(2'd0, v);
        chk("R6 status", v, 8'h05);
        wr(2'd0, 8'h00);
        cyc();
        ch_req = 8'h04;
        cyc();
        ch_req = '0;
        cyc();
        chk("R6 unblocked", {7'd0, irq0}, 8'h01);

        // R8 flag write-0 clear, write-1 no effect
        wr(2'd3, 8'h01);
        chk("R8 grp1 cleared", {7'd0, irq1}, 8'h00);
        chk("R8 grp0 kept", {7'd0, irq0}, 8'h01);
        rd(2'd3, v);
        chk("R8 flag read", v, 8'h01);

        // R2 R7 base timer
        bt_ovf = 1'b1;
        cyc();
        bt_ovf = 1'b0;
        chk("R2 ovf flag", {7'd0, irqb}, 8'h01);
        chk("R7 base dma", {7'd0, dma_b}, 8'h01);
        cyc();
        chk("R7 base dma single", {7'd0, dma_b}, 8'h00);
        ackb = 1'b1;
        cyc();
        ackb = 1'b0;
        chk("R5 base ack", {7'd0, irqb}, 8'h00);
        bt_rst = 1'b1;
        cyc();
        bt_rst = 1'b0;
        chk("R2 rst flag", {7'd0, irqb}, 8'h01);

        // R9 set wins
        ackb = 1'b1; bt_ovf = 1'b1;
        cyc();
        ackb = 1'b0; bt_ovf = 1'b0;
        chk("R9 flag set wins", {7'd0, irqb}, 8'h01);
        we = 1'b1; sel = 2'd0; wdata = 8'h00; ch_req = 8'h08;
        cyc();
        we = 1'b0; ch_req = '0;
        rd(2'd0, v);
        chk("R9 status set wins", v, 8'h08);

        finish_run();
    end
endmodule